// File: doc/BRIEF.md
# One-Second Epoch Counters with Reference and Operational Status

This block counts one-second epochs marked by an external pulse-per-second (1PPS) input and publishes the counts in a byte-addressed status record. It keeps two epoch counters. The first keeps its value across reset commands and is cleared only by hardware reset. The second is cleared by hardware reset and also by a reset command. After being cleared, a counter holds at zero until it sees its first synchronized rising edge on the 1PPS input. That edge arms the counter. Every later edge adds one.

The block also produces three status flags. The reference-present flag shows whether a 1PPS edge has been seen within a timeout window. The operational flag follows a sequence driven by commands and calibration. The mode flag repeats the modulation selection given by the last control command. While the block is not operational, the operational flag also blocks an update-valid strobe, which carries rate or frequency updates.

A framing block reads the two counters byte by byte through a combinational record port. Each counter is a 32-bit word sent least significant byte first, and its top bit is always zero.

Top module: `pps_epoch_status`

## Requirements
- R1: After hardware reset, both counters read zero and are unarmed. The reference-present, operational and mode flags are 0, and every record byte reads 0.
- R2: The raw 1PPS input is synchronized, and only its rising edges count as epochs, so a level held high gives one epoch. The first edge after a clear arms a counter and leaves it at 0. Each later edge adds 1. Without an edge, a counter does not change.
- R3: The hardware-epoch counter is cleared only by hardware reset. A reset command leaves it unchanged.
- R4: A reset command clears the command-epoch counter and returns it to the unarmed state. If a reset command and a 1PPS edge arrive in the same cycle, the reset command wins.
- R5: A counter of CNT_W bits that is at its all-ones value wraps to 0 on the next epoch.
- R6: Record addresses 16 to 19 hold the command-epoch word and addresses 20 to 23 hold the hardware-epoch word. Each word is least significant byte first, so bits 7..0 are at the lower address. Bit 7 of bytes 19 and 23, which is word bit 31, is always 0. All other addresses read 0.
- R7: The operational flag is 0 after hardware reset and 1 cycle after a reset command. It becomes 1 one cycle after a control command has been received and cal_done is high. A reset command in the same cycle as a control command leaves the flag at 0.
- R8: upd_vld_out repeats upd_vld_in while operational is 1 and is 0 while operational is 0.
- R9: mode_qpsk takes the value of ctrl_mode at each control command, where 0 means BPSK and 1 means QPSK. A reset command does not change it.
- R10: ref_present becomes 1 after a 1PPS edge. It returns to 0 once TIMEOUT_CYC cycles have passed with no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| cmd_reset | input | 1 | Reset-command strobe |
| cmd_ctrl | input | 1 | Control-command strobe |
| ctrl_mode | input | 1 | Modulation select sampled with cmd_ctrl (0 BPSK, 1 QPSK) |
| cal_done | input | 1 | Internal calibration complete |
| pps_in | input | 1 | Raw, unsynchronized 1PPS input |
| upd_vld_in | input | 1 | Incoming rate/frequency update strobe |
| upd_vld_out | output | 1 | Update strobe after gating by the operational flag |
| rec_addr | input | ADDR_W | Status record byte address |
| rec_data | output | 8 | Status record byte at rec_addr |
| ref_present | output | 1 | 1PPS reference present |
| operational | output | 1 | Operational flag |
| mode_qpsk | output | 1 | Modulation mode echo |

## Verification
A counter whose armed state is wrong shows up at the record port on the second edge after a clear: it is one count high or one count low. This happens 3 cycles after that edge reaches pps_in, because of the two synchronizer stages and the edge register. A missed or misplaced clear shows up at the first read of the record after the reset command, as a nonzero command word, or as a hardware word that has dropped. An error in the operational sequencer shows up 1 cycle later on both operational and upd_vld_out. A wrong timeout shows up only when the window ends, so the bench checks ref_present on each side of that boundary.

// File: rtl/pps_epoch_pkg.sv
package pps_epoch_pkg;
   localparam int unsigned WORD_W       = 32;
   localparam int unsigned BYTES_PER_W  = WORD_W / 8;
   localparam int unsigned REC_CMD_BASE = 16;
   localparam int unsigned REC_HW_BASE  = 20;
   localparam int unsigned N_COUNTERS   = 2;
   localparam int unsigned IDX_CMD      = 0;
   localparam int unsigned IDX_HW       = 1;

   typedef logic [WORD_W-1:0] epoch_word_t;
endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pps_raw,
   output logic edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pps_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pps_raw};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign edge_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/epoch_counter.sv
module epoch_counter #(
   parameter int unsigned CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_o,
   output logic             armed_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (tick) begin
         if (!armed_q) armed_q <= 1'b1;
         else          cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign cnt_o   = cnt_q;
   assign armed_o = armed_q;
endmodule

// File: rtl/ref_monitor.sv
module ref_monitor #(
   parameter int unsigned TIMEOUT_CYC = 187_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic present_o
);
   localparam int unsigned TMR_W = $clog2(TIMEOUT_CYC + 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("ref_monitor: TIMEOUT_CYC must be at least 2");
   end

   logic [TMR_W-1:0] timer_q;
   logic             present_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timer_q   <= '0;
         present_q <= 1'b0;
      end else if (tick) begin
         timer_q   <= '0;
         present_q <= 1'b1;
      end else if (present_q) begin
         if (timer_q == TMR_W'(TIMEOUT_CYC - 1)) begin
            present_q <= 1'b0;
            timer_q   <= '0;
         end else begin
            timer_q <= timer_q + 1'b1;
         end
      end
   end

   assign present_o = present_q;
endmodule

// File: rtl/op_sequencer.sv
module op_sequencer (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_reset,
   input  logic cmd_ctrl,
   input  logic ctrl_mode,
   input  logic cal_done,
   output logic operational_o,
   output logic mode_o
);
   logic ctrl_seen_q;
   logic op_q;
   logic mode_q;
   logic ctrl_seen_d;

   assign ctrl_seen_d = ctrl_seen_q | cmd_ctrl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_seen_q <= 1'b0;
         op_q        <= 1'b0;
         mode_q      <= 1'b0;
      end else begin
         if (cmd_ctrl) mode_q <= ctrl_mode;
         if (cmd_reset) begin
            ctrl_seen_q <= 1'b0;
            op_q        <= 1'b0;
         end else begin
            ctrl_seen_q <= ctrl_seen_d;
            if (ctrl_seen_d && cal_done) op_q <= 1'b1;
         end
      end
   end

   assign operational_o = op_q;
   assign mode_o        = mode_q;
endmodule

// File: rtl/pps_epoch_status.sv
module pps_epoch_status
   import pps_epoch_pkg::*;
#(
   parameter int unsigned CNT_W       = 31,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TIMEOUT_CYC = 187_500_000,
   parameter int unsigned ADDR_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_reset,
   input  logic              cmd_ctrl,
   input  logic              ctrl_mode,
   input  logic              cal_done,
   input  logic              pps_in,
   input  logic              upd_vld_in,
   output logic              upd_vld_out,
   input  logic [ADDR_W-1:0] rec_addr,
   output logic [7:0]        rec_data,
   output logic              ref_present,
   output logic              operational,
   output logic              mode_qpsk
);
   if (CNT_W < 1 || CNT_W > WORD_W - 1) begin : g_bad_cnt_w
      $error("pps_epoch_status: CNT_W must lie in 1..31");
   end
   if ((1 << ADDR_W) < REC_HW_BASE + BYTES_PER_W) begin : g_bad_addr_w
      $error("pps_epoch_status: ADDR_W too narrow for record");
   end

   logic        pps_edge;
   epoch_word_t words [N_COUNTERS];
   epoch_word_t word_cmd;
   epoch_word_t word_hw;

   pps_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .pps_raw(pps_in), .edge_o(pps_edge)
   );

   for (genvar i = 0; i < N_COUNTERS; i++) begin : g_cnt
      logic [CNT_W-1:0] cnt;
      logic             armed;
      logic             clr;
      if (i == IDX_CMD) begin : g_cmd_clr
         assign clr = cmd_reset;
      end else begin : g_hw_clr
         assign clr = 1'b0;
      end
      epoch_counter #(.CNT_W(CNT_W)) cnt_i (
         .clk(clk), .rst_n(rst_n), .clr(clr), .tick(pps_edge),
         .cnt_o(cnt), .armed_o(armed)
      );
      assign words[i] = epoch_word_t'(cnt);
   end

   assign word_cmd = words[IDX_CMD];
   assign word_hw  = words[IDX_HW];

   ref_monitor #(.TIMEOUT_CYC(TIMEOUT_CYC)) ref_i (
      .clk(clk), .rst_n(rst_n), .tick(pps_edge), .present_o(ref_present)
   );

   op_sequencer seq_i (
      .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_ctrl(cmd_ctrl),
      .ctrl_mode(ctrl_mode), .cal_done(cal_done),
      .operational_o(operational), .mode_o(mode_qpsk)
   );

   assign upd_vld_out = upd_vld_in & operational;

   always_comb begin
      rec_data = 8'h00;
      for (int j = 0; j < BYTES_PER_W; j++) begin
         if (rec_addr == ADDR_W'(REC_CMD_BASE + j)) rec_data = word_cmd[8*j +: 8];
         if (rec_addr == ADDR_W'(REC_HW_BASE + j))  rec_data = word_hw[8*j +: 8];
      end
   end
endmodule

// File: rtl/pps_epoch_status_chk.sv
module pps_epoch_status_chk
   import pps_epoch_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_reset,
   input logic              cmd_ctrl,
   input logic              ctrl_mode,
   input logic              cal_done,
   input logic              pps_edge,
   input logic              operational,
   input logic              mode_qpsk,
   input logic              ref_present,
   input epoch_word_t       word_cmd,
   input epoch_word_t       word_hw,
   input logic [ADDR_W-1:0] rec_addr,
   input logic [7:0]        rec_data
);
   // R4
   cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (word_cmd == '0));

   // R3
   hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_reset && !pps_edge) |=> $stable(word_hw));

   // R2
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pps_edge && !cmd_reset) |=> $stable(word_cmd));

   // R7
   op_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> !operational);

   // R7
   op_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(operational) |-> $past(cal_done));

   // R9
   mode_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ctrl |=> (mode_qpsk == $past(ctrl_mode)));

   // R6
   msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_addr == ADDR_W'(REC_CMD_BASE + 3) || rec_addr == ADDR_W'(REC_HW_BASE + 3))
      |-> !rec_data[7]);

   // R10
   ref_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_present) |-> $past(pps_edge));
endmodule

bind pps_epoch_status pps_epoch_status_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_ctrl(cmd_ctrl),
   .ctrl_mode(ctrl_mode), .cal_done(cal_done), .pps_edge(pps_edge),
   .operational(operational), .mode_qpsk(mode_qpsk), .ref_present(ref_present),
   .word_cmd(word_cmd), .word_hw(word_hw), .rec_addr(rec_addr), .rec_data(rec_data)
);

// File: tb/pps_epoch_status_tb_top.sv
`timescale 1ns/100ps
module pps_epoch_status_tb_top;
   localparam int unsigned TMO = 300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_reset = 1'b0, cmd_ctrl = 1'b0, ctrl_mode = 1'b0, cal_done = 1'b0;
   logic       pps_in = 1'b0, upd_vld_in = 1'b0;
   logic [4:0] rec_addr = '0;
   logic       upd_vld_out, ref_present, operational, mode_qpsk;
   logic [7:0] rec_data;
   logic       upd_w, ref_w, op_w, mode_w;
   logic [7:0] rec_data_w;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pps_epoch_status #(.CNT_W(31), .TIMEOUT_CYC(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_ctrl(cmd_ctrl),
      .ctrl_mode(ctrl_mode), .cal_done(cal_done), .pps_in(pps_in),
      .upd_vld_in(upd_vld_in), .upd_vld_out(upd_vld_out), .rec_addr(rec_addr),
      .rec_data(rec_data), .ref_present(ref_present), .operational(operational),
      .mode_qpsk(mode_qpsk)
   );

   pps_epoch_status #(.CNT_W(3), .TIMEOUT_CYC(TMO)) dut_wrap_i (
      .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_ctrl(cmd_ctrl),
      .ctrl_mode(ctrl_mode), .cal_done(cal_done), .pps_in(pps_in),
      .upd_vld_in(upd_vld_in), .upd_vld_out(upd_w), .rec_addr(rec_addr),
      .rec_data(rec_data_w), .ref_present(ref_w), .operational(op_w),
      .mode_qpsk(mode_w)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic read_words(input logic [4:0] base, output logic [31:0] w, output logic [31:0] ww);
      for (int b = 0; b < 4; b++) begin
         rec_addr = base + 5'(b);
         #0.2;
         w[8*b +: 8]  = rec_data;
         ww[8*b +: 8] = rec_data_w;
      end
   endtask

   task automatic pulse(input bit with_rst);
      @(negedge clk) pps_in = 1'b1;
      @(negedge clk);
      @(negedge clk) if (with_rst) cmd_reset = 1'b1;
      @(negedge clk) cmd_reset = 1'b0;
      repeat (3) @(negedge clk);
      pps_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_cmd_reset();
      @(negedge clk) cmd_reset = 1'b1;
      @(negedge clk) cmd_reset = 1'b0;
   endtask

   // op: 0 pulse, 1 reset command, 2 pulse with reset command on the edge cycle
   localparam int NV = 9;
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 8'd0, 8'd0},
      {2'd0, 8'd1, 8'd1},
      {2'd0, 8'd2, 8'd2},
      {2'd1, 8'd0, 8'd2},
      {2'd0, 8'd0, 8'd3},
      {2'd0, 8'd1, 8'd4},
      {2'd2, 8'd0, 8'd5},
      {2'd0, 8'd0, 8'd6},
      {2'd0, 8'd1, 8'd7}
   };

   initial begin
      logic [31:0] wc, wcw, wh, whw;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(!ref_present && !operational && !mode_qpsk, "R1", {ref_present, operational, mode_qpsk}, 0);
      for (int a = 0; a < 32; a++) begin
         rec_addr = 5'(a);
         #0.2;
         check(rec_data == 8'h00, "R1", rec_data, 0);
      end

      // R7 / R8 / R9 operational sequencing
      upd_vld_in = 1'b1;
      ctrl_mode  = 1'b1;
      @(negedge clk) cmd_ctrl = 1'b1;
      @(negedge clk) cmd_ctrl = 1'b0;
      repeat (3) @(negedge clk);
      check(!operational, "R7", operational, 0);
      check(!upd_vld_out, "R8", upd_vld_out, 0);
      check(mode_qpsk, "R9", mode_qpsk, 1);
      cal_done = 1'b1;
      @(negedge clk);
      check(operational, "R7", operational, 1);
      check(upd_vld_out, "R8", upd_vld_out, 1);
      upd_vld_in = 1'b0;
      #0.2 check(!upd_vld_out, "R8", upd_vld_out, 0);
      upd_vld_in = 1'b1;
      send_cmd_reset();
      check(!operational, "R7", operational, 0);
      check(!upd_vld_out, "R8", upd_vld_out, 0);
      check(mode_qpsk, "R9", mode_qpsk, 1);
      ctrl_mode = 1'b0;
      @(negedge clk) begin cmd_ctrl = 1'b1; cmd_reset = 1'b1; end
      @(negedge clk) begin cmd_ctrl = 1'b0; cmd_reset = 1'b0; end
      @(negedge clk);
      check(!operational, "R7", operational, 0);
      @(negedge clk) cmd_ctrl = 1'b1;
      @(negedge clk) cmd_ctrl = 1'b0;
      check(operational, "R7", operational, 1);
      check(!mode_qpsk, "R9", mode_qpsk, 0);

      // R2 R3 R4 R6 counting vectors
      for (int v = 0; v < NV; v++) begin
         case (VEC[v][17:16])
            2'd0: pulse(1'b0);
            2'd1: send_cmd_reset();
            default: pulse(1'b1);
         endcase
         read_words(5'd16, wc, wcw);
         read_words(5'd20, wh, whw);
         check(wc == 32'(VEC[v][15:8]), "R4 R2 cmd word", wc, VEC[v][15:8]);
         check(wh == 32'(VEC[v][7:0]), "R3 R2 hw word", wh, VEC[v][7:0]);
         check(wc[31] == 1'b0 && wh[31] == 1'b0, "R6", {wc[31], wh[31]}, 0);
      end
      check(ref_present, "R10", ref_present, 1);

      // R5 wrap on the narrow instance
      read_words(5'd20, wh, whw);
      check(whw == 32'd7, "R5 pre-wrap", whw, 7);
      pulse(1'b0);
      read_words(5'd20, wh, whw);
      check(whw == 32'd0, "R5 wrap", whw, 0);
      check(wh == 32'd8, "R2", wh, 8);
      read_words(5'd16, wc, wcw);
      check(wcw == 32'd2 && wc == 32'd2, "R2", wc, 2);
      rec_addr = 5'd24;
      #0.2 check(rec_data == 8'h00, "R6", rec_data, 0);

      // R10 timeout boundary: last edge about 8 cycles before this point
      repeat (TMO - 60) @(negedge clk);
      check(ref_present, "R10", ref_present, 1);
      repeat (70) @(negedge clk);
      check(!ref_present, "R10", ref_present, 0);

      // R3 hardware reset clears the hardware-epoch counter
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      read_words(5'd20, wh, whw);
      check(wh == 32'd0, "R3 R1", wh, 0);
      check(!operational, "R1", operational, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule